// File: doc/BRIEF.md
# Ordered Store Buffer with Flush-on-Sync and Reservation Monitor

This block sits between a processor's load/store unit and a single data memory port. Stores from the core are queued in a small FIFO and written to memory strictly in the order they were issued. A load can be answered from the queue when the youngest queued store to the same word covers every byte. A load that only partly overlaps queued stores waits until they are all written. A load that matches no queued store goes straight to memory and takes the port ahead of the queued stores. The result is total store order: stores stay ordered among themselves, and a later load may complete before earlier stores are written.

Three operations make the core wait until the queue is empty: a memory-sync, a load-reserve and a store-conditional. A load-reserve reads the word after the flush and arms a one-entry reservation on that word. A store-conditional writes only while that reservation is still armed for its word. It reports the outcome with a success flag, so the core can retry the pair when it fails. A write by another agent to the reserved word, seen on the snoop input, disarms the reservation. The flush covers only stores queued here. Stores waiting in another agent's buffer are not seen until that agent writes them out.

Top module: `sbuf_tso_top`

## Requirements
- R1: Queued stores reach memory in issue order, one write per store, and only the bytes whose enable bit is set change (`mem_be` bit i covers data bits 8i+7..8i).
- R2: When DEPTH stores are queued, a store request (op code 1) is held off with `req_ready` low until an entry drains.
- R3: A load (op code 0) whose word address matches queued stores, where the youngest match has all byte enables set, returns that youngest entry's data on the cycle after acceptance, with no memory read and `rsp_sc_ok` low.
- R4: A load whose youngest matching queued store has any byte enable clear gives no response until the queue is empty. It then reads memory and returns the merged word.
- R5: A load that matches no queued store issues its memory read before any queued store is written, and the read is never delayed by those stores.
- R6: A memory-sync (op code 2) responds only after every store queued before it has been written to memory. Its `rsp_sc_ok` is low.
- R7: A load-reserve (op code 3) first waits for the queue to empty, then reads memory, returns the word and arms the reservation on that word.
- R8: A store-conditional (op code 4) whose word holds an armed reservation once the queue is empty performs one memory write. It responds with `rsp_sc_ok` high on the cycle after that write is accepted. Either outcome disarms the reservation.
- R9: A store-conditional without an armed reservation on its word performs no write. It responds with `rsp_sc_ok` low on the cycle after the queue is found empty.
- R10: A snoop to the reserved word disarms the reservation, including a snoop in the same cycle as the store-conditional's check. A snoop to any other word leaves the reservation armed.
- R11: Reset (synchronous, active high) empties the queue without writing it, disarms the reservation and drops any pending flush, so no response follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core presents an operation |
| req_op | input | 3 | 0 load, 1 store, 2 sync, 3 load-reserve, 4 store-conditional |
| req_addr | input | ADDR_W | Byte address (word aligned) |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| req_ready | output | 1 | Operation accepted this cycle when high with req_valid |
| rsp_valid | output | 1 | One-cycle response pulse for load, sync, load-reserve and store-conditional |
| rsp_rdata | output | DATA_W | Load or load-reserve data |
| rsp_sc_ok | output | 1 | Store-conditional success flag |
| mem_req_valid | output | 1 | Memory request this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Write data |
| mem_be | output | DATA_W/8 | Write byte enables |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | DATA_W | Read data |
| snoop_valid | input | 1 | Another agent writes the snooped address |
| snoop_addr | input | ADDR_W | Snooped byte address |

## Verification
The two functions that can meet in one cycle are a snoop that disarms the reservation and the store-conditional's reservation check at the end of its flush. The bench accepts a store-conditional on an empty queue and pulses a snoop to the reserved word in the very next cycle, which is the check cycle. It then requires a failed flag, no memory write and an unchanged memory word. A snoop to a neighbouring word is also sent, and the bench requires that the store-conditional after it still succeeds.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_SYNC  = 3'd2,
    OP_LR    = 3'd3,
    OP_SC    = 3'd4
  } op_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_LD_HOLD,
    ST_LD_ISSUE,
    ST_LD_WAIT,
    ST_SC_ISSUE
  } state_t;
endpackage

// File: rtl/sbuf_fifo.sv
// Ordered store queue with a youngest-match lookup across all live entries.
module sbuf_fifo #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 push,
  input  logic [ADDR_W-1:0]    push_addr,
  input  logic [DATA_W-1:0]    push_data,
  input  logic [DATA_W/8-1:0]  push_be,
  input  logic                 pop,
  output logic [ADDR_W-1:0]    head_addr,
  output logic [DATA_W-1:0]    head_data,
  output logic [DATA_W/8-1:0]  head_be,
  output logic                 empty,
  output logic                 full,
  input  logic [ADDR_W-1:0]    look_addr,
  output logic                 fwd_hit,
  output logic                 fwd_full,
  output logic [DATA_W-1:0]    fwd_data
);
  localparam int BE_W = DATA_W / 8;
  localparam int OFS  = $clog2(BE_W);
  localparam int PW   = $clog2(DEPTH);
  localparam int CW   = PW + 1;

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [BE_W-1:0]   be_q   [DEPTH];
  logic [PW-1:0]     rd_ptr, wr_ptr;
  logic [CW-1:0]     cnt;
  logic [BE_W-1:0]   fwd_be;

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr] <= push_addr;
      data_q[wr_ptr] <= push_data;
      be_q[wr_ptr]   <= push_be;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign head_addr = addr_q[rd_ptr];
  assign head_data = data_q[rd_ptr];
  assign head_be   = be_q[rd_ptr];
  assign empty     = (cnt == '0);
  assign full      = (cnt == CW'(DEPTH));

  // Scan oldest to youngest; the last live match wins.
  always_comb begin
    fwd_hit  = 1'b0;
    fwd_be   = '0;
    fwd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < cnt &&
          addr_q[rd_ptr + PW'(i)][ADDR_W-1:OFS] == look_addr[ADDR_W-1:OFS]) begin
        fwd_hit  = 1'b1;
        fwd_be   = be_q[rd_ptr + PW'(i)];
        fwd_data = data_q[rd_ptr + PW'(i)];
      end
    end
  end

  assign fwd_full = fwd_hit && (&fwd_be);
endmodule

// File: rtl/sbuf_resv.sv
// Single-word reservation, disarmed by a consuming store-conditional or a snoop.
module sbuf_resv #(
  parameter int ADDR_W = 16,
  parameter int OFS    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic [ADDR_W-1:0] arm_addr,
  input  logic              consume,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              armed,
  output logic [ADDR_W-1:0] held_addr,
  output logic              match
);
  localparam int WW = ADDR_W - OFS;

  logic [WW-1:0] snoop_w;
  logic          snoop_kill, snoop_arm_kill, snoop_chk_kill;

  assign snoop_w        = snoop_addr[ADDR_W-1:OFS];
  assign snoop_kill     = snoop_valid && armed && (snoop_w == held_addr[ADDR_W-1:OFS]);
  assign snoop_arm_kill = snoop_valid && (snoop_w == arm_addr[ADDR_W-1:OFS]);
  assign snoop_chk_kill = snoop_valid && (snoop_w == chk_addr[ADDR_W-1:OFS]);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      held_addr <= '0;
    end else begin
      if (consume || snoop_kill) armed <= 1'b0;
      if (arm) begin
        armed     <= !snoop_arm_kill;
        held_addr <= arm_addr;
      end
    end
  end

  assign match = armed && (held_addr[ADDR_W-1:OFS] == chk_addr[ADDR_W-1:OFS])
                 && !snoop_chk_kill;
endmodule

// File: rtl/sbuf_tso_top.sv
module sbuf_tso_top
  import sbuf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [2:0]           req_op,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [DATA_W/8-1:0]  req_be,
  output logic                 req_ready,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 rsp_sc_ok,
  output logic                 mem_req_valid,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  output logic [DATA_W/8-1:0]  mem_be,
  input  logic                 mem_ready,
  input  logic                 mem_rvalid,
  input  logic [DATA_W-1:0]    mem_rdata,
  input  logic                 snoop_valid,
  input  logic [ADDR_W-1:0]    snoop_addr
);
  localparam int BE_W = DATA_W / 8;
  localparam int OFS  = $clog2(BE_W);

  state_t            state;
  op_t               cur_op, in_op;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_data;
  logic [BE_W-1:0]   cur_be;

  logic              accept, push, pop, core_port;
  logic              buf_empty, buf_full, fwd_hit, fwd_full;
  logic [DATA_W-1:0] fwd_data, head_data;
  logic [ADDR_W-1:0] head_addr;
  logic [BE_W-1:0]   head_be;
  logic              resv_arm, resv_consume, resv_match, resv_valid;
  logic [ADDR_W-1:0] resv_addr;

  assign in_op     = op_t'(req_op);
  assign req_ready = (state == ST_IDLE) && !(in_op == OP_STORE && buf_full);
  assign accept    = req_valid && req_ready;
  assign push      = accept && (in_op == OP_STORE);

  // The core's own read or conditional write owns the port ahead of draining.
  assign core_port     = (state == ST_LD_ISSUE) || (state == ST_SC_ISSUE);
  assign mem_req_valid = core_port || !buf_empty;
  assign mem_we        = core_port ? (state == ST_SC_ISSUE) : 1'b1;
  assign mem_addr      = core_port ? cur_addr : head_addr;
  assign mem_wdata     = core_port ? cur_data : head_data;
  assign mem_be        = core_port ? ((state == ST_LD_ISSUE) ? '1 : cur_be) : head_be;
  assign pop           = !core_port && !buf_empty && mem_ready;

  sbuf_fifo #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst(rst),
    .push(push), .push_addr(req_addr), .push_data(req_wdata), .push_be(req_be),
    .pop(pop),
    .head_addr(head_addr), .head_data(head_data), .head_be(head_be),
    .empty(buf_empty), .full(buf_full),
    .look_addr(req_addr), .fwd_hit(fwd_hit), .fwd_full(fwd_full), .fwd_data(fwd_data)
  );

  assign resv_arm     = (state == ST_LD_WAIT) && mem_rvalid && (cur_op == OP_LR);
  assign resv_consume = (state == ST_FLUSH) && buf_empty && (cur_op == OP_SC);

  sbuf_resv #(.ADDR_W(ADDR_W), .OFS(OFS)) u_resv (
    .clk(clk), .rst(rst),
    .arm(resv_arm), .arm_addr(cur_addr), .consume(resv_consume),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr), .chk_addr(cur_addr),
    .armed(resv_valid), .held_addr(resv_addr), .match(resv_match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_op    <= OP_LOAD;
      cur_addr  <= '0;
      cur_data  <= '0;
      cur_be    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_sc_ok <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          cur_op   <= in_op;
          cur_addr <= req_addr;
          cur_data <= req_wdata;
          cur_be   <= req_be;
          case (in_op)
            OP_STORE: ;
            OP_LOAD: begin
              if (fwd_full) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= fwd_data;
                rsp_sc_ok <= 1'b0;
              end else if (fwd_hit) begin
                state <= ST_LD_HOLD;
              end else begin
                state <= ST_LD_ISSUE;
              end
            end
            default: state <= ST_FLUSH;
          endcase
        end
        ST_FLUSH: if (buf_empty) begin
          case (cur_op)
            OP_LR: state <= ST_LD_ISSUE;
            OP_SC: begin
              if (resv_match) begin
                state <= ST_SC_ISSUE;
              end else begin
                rsp_valid <= 1'b1;
                rsp_sc_ok <= 1'b0;
                state     <= ST_IDLE;
              end
            end
            default: begin
              rsp_valid <= 1'b1;
              rsp_sc_ok <= 1'b0;
              state     <= ST_IDLE;
            end
          endcase
        end
        ST_LD_HOLD:  if (buf_empty) state <= ST_LD_ISSUE;
        ST_LD_ISSUE: if (mem_ready) state <= ST_LD_WAIT;
        ST_LD_WAIT: if (mem_rvalid) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= mem_rdata;
          rsp_sc_ok <= 1'b0;
          state     <= ST_IDLE;
        end
        ST_SC_ISSUE: if (mem_ready) begin
          rsp_valid <= 1'b1;
          rsp_sc_ok <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbuf_tso_chk.sv
module sbuf_tso_chk #(
  parameter int ADDR_W = 16,
  parameter int OFS    = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [2:0]        req_op,
  input logic              req_ready,
  input logic              buf_full,
  input logic              buf_empty,
  input logic              rsp_valid,
  input logic              rsp_sc_ok,
  input logic [2:0]        cur_op,
  input logic              mem_req_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic              snoop_valid,
  input logic [ADDR_W-1:0] snoop_addr,
  input logic              resv_valid,
  input logic [ADDR_W-1:0] resv_addr
);
  // R2
  a_r2_no_push_when_full: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd1 && buf_full) |-> !req_ready);

  // R6
  a_r6_sync_after_drain: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && cur_op == 3'd2) |-> buf_empty);

  // R8
  a_r8_sc_ok_after_write: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_sc_ok) |-> $past(mem_req_valid && mem_ready && mem_we));

  // R10
  a_r10_snoop_disarms: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid && resv_valid &&
     snoop_addr[ADDR_W-1:OFS] == resv_addr[ADDR_W-1:OFS]) |=> !resv_valid);

  // R11
  a_r11_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !mem_req_valid && !resv_valid));
endmodule

bind sbuf_tso_top sbuf_tso_chk #(.ADDR_W(ADDR_W), .OFS(OFS)) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_ready(req_ready),
  .buf_full(buf_full), .buf_empty(buf_empty), .rsp_valid(rsp_valid), .rsp_sc_ok(rsp_sc_ok),
  .cur_op(cur_op), .mem_req_valid(mem_req_valid), .mem_ready(mem_ready), .mem_we(mem_we),
  .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
  .resv_valid(resv_valid), .resv_addr(resv_addr)
);

// File: tb/test_sbuf_tso_top.sv
`timescale 1ns/1ps
module test_sbuf_tso_top;
  localparam int AW = 16, DW = 32, BW = 4;
  localparam logic [2:0] LD = 3'd0, STR = 3'd1, SYN = 3'd2, LRS = 3'd3, SCD = 3'd4;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [BW-1:0] req_be = '0;
  logic req_ready, rsp_valid, rsp_sc_ok;
  logic [DW-1:0] rsp_rdata;
  logic mem_req_valid, mem_we, mem_ready, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata = '0;
  logic [BW-1:0] mem_be;
  logic snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic mem_stall = 1'b0;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;
  assign mem_ready = !mem_stall;

  sbuf_tso_top #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(4)) i_sbuf_tso_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_sc_ok(rsp_sc_ok), .mem_req_valid(mem_req_valid),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr));

  // Behavioural memory with an access log.
  logic [DW-1:0] mem [16];
  logic          log_we   [256];
  logic [AW-1:0] log_addr [256];
  int log_n = 0, wr_count = 0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (rst) begin
      for (int i = 0; i < 16; i++) mem[i] = 32'hA000_0000 + i;
    end else if (mem_req_valid && mem_ready) begin
      if (log_n < 256) begin
        log_we[log_n]   = mem_we;
        log_addr[log_n] = mem_addr;
      end
      log_n++;
      if (mem_we) begin
        for (int b = 0; b < BW; b++)
          if (mem_be[b]) mem[mem_addr[5:2]][8*b +: 8] = mem_wdata[8*b +: 8];
        wr_count++;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[5:2]];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] wa(input int idx);
    return AW'(idx * 4);
  endfunction

  task automatic send(input logic [2:0] op, input int idx, input logic [31:0] d,
                      input logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = wa(idx); req_wdata = d; req_be = be;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(output int waited, output logic [31:0] d, output logic ok);
    waited = 0;
    while (!rsp_valid && waited < 60) begin @(negedge clk); waited++; end
    d = rsp_rdata; ok = rsp_sc_ok;
    if (!rsp_valid) chk("response timeout", 32'd0, 32'd1);
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (rsp_valid) seen = 1; end
    chk(tag, 32'(seen), 32'd0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R11 ready after reset", 32'(req_ready), 32'd1);
    chk("R11 no rsp after reset", 32'(rsp_valid), 32'd0);
    chk("R11 no mem req after reset", 32'(mem_req_valid), 32'd0);
  endtask

  task automatic t_order_full();
    int base = log_n;
    mem_stall = 1'b1;
    send(STR, 1, 32'h1111_1111, 4'hF);
    send(STR, 2, 32'h2222_2222, 4'hF);
    send(STR, 3, 32'h0000_3333, 4'h3);
    send(STR, 1, 32'h4444_4444, 4'hF);
    @(negedge clk);
    req_valid = 1'b1; req_op = STR; req_addr = wa(4); req_wdata = 32'h9999_9999; req_be = 4'hF;
    #1; chk("R2 full holds off store", 32'(req_ready), 32'd0);
    repeat (2) @(negedge clk);
    #1; chk("R2 still held", 32'(req_ready), 32'd0);
    req_valid = 1'b0;
    mem_stall = 1'b0;
    repeat (8) @(negedge clk);
    chk("R1 write count", 32'(log_n - base), 32'd4);
    chk("R1 order 0", 32'(log_addr[base]),   32'(wa(1)));
    chk("R1 order 1", 32'(log_addr[base+1]), 32'(wa(2)));
    chk("R1 order 2", 32'(log_addr[base+2]), 32'(wa(3)));
    chk("R1 order 3", 32'(log_addr[base+3]), 32'(wa(1)));
    chk("R1 word1", mem[1], 32'h4444_4444);
    chk("R1 byte enables", mem[3], 32'hA000_3333);
  endtask

  task automatic t_forward();
    int base = log_n, w; logic [31:0] d; logic ok;
    mem_stall = 1'b1;
    send(STR, 5, 32'h0000_00AA, 4'h1);
    send(STR, 5, 32'h5555_5555, 4'hF);
    send(STR, 5, 32'h6666_6666, 4'hF);
    send(LD, 5, 32'h0, 4'hF);
    wait_rsp(w, d, ok);
    chk("R3 youngest data", d, 32'h6666_6666);
    chk("R3 next-cycle response", 32'(w), 32'd0);
    chk("R3 ok flag low", 32'(ok), 32'd0);
    chk("R3 no memory access", 32'(log_n - base), 32'd0);
    mem_stall = 1'b0;
    repeat (6) @(negedge clk);
    chk("R1 final word5", mem[5], 32'h6666_6666);
  endtask

  task automatic t_partial();
    int base = log_n, w; logic [31:0] d; logic ok;
    mem_stall = 1'b1;
    send(STR, 6, 32'h0000_BEEF, 4'h3);
    send(LD, 6, 32'h0, 4'hF);
    quiet(5, "R4 partial load waits");
    mem_stall = 1'b0;
    wait_rsp(w, d, ok);
    chk("R4 merged data", d, 32'hA000_BEEF);
    chk("R4 write before read", 32'(log_we[base]), 32'd1);
    chk("R4 read after drain", 32'(log_we[base+1]), 32'd0);
  endtask

  task automatic t_bypass();
    int base = log_n, w; logic [31:0] d; logic ok;
    mem_stall = 1'b1;
    send(STR, 7, 32'hDEAD_0007, 4'hF);
    send(STR, 8, 32'hDEAD_0008, 4'hF);
    send(LD, 9, 32'h0, 4'hF);
    mem_stall = 1'b0;
    wait_rsp(w, d, ok);
    chk("R5 miss data", d, 32'hA000_0009);
    chk("R5 read goes first", 32'(log_we[base]), 32'd0);
    chk("R5 read address", 32'(log_addr[base]), 32'(wa(9)));
    repeat (4) @(negedge clk);
    chk("R1 word7 after bypass", mem[7], 32'hDEAD_0007);
  endtask

  task automatic t_sync();
    int base = wr_count, w; logic [31:0] d; logic ok;
    mem_stall = 1'b1;
    send(STR, 10, 32'h1010_1010, 4'hF);
    send(STR, 11, 32'h1111_0000, 4'hF);
    send(SYN, 0, 32'h0, 4'h0);
    quiet(5, "R6 sync waits for drain");
    mem_stall = 1'b0;
    wait_rsp(w, d, ok);
    chk("R6 all writes done", 32'(wr_count - base), 32'd2);
    chk("R6 ok low", 32'(ok), 32'd0);
  endtask

  task automatic t_lr_sc_ok();
    int w; logic [31:0] d; logic ok;
    mem_stall = 1'b1;
    send(STR, 12, 32'hC0C0_C0C0, 4'hF);
    send(LRS, 12, 32'h0, 4'hF);
    quiet(3, "R7 load-reserve waits for drain");
    mem_stall = 1'b0;
    wait_rsp(w, d, ok);
    chk("R7 reads flushed value", d, 32'hC0C0_C0C0);
    mem_stall = 1'b1;
    send(SCD, 12, 32'h5C5C_5C5C, 4'hF);
    quiet(4, "R8 no flag before write accepted");
    mem_stall = 1'b0;
    wait_rsp(w, d, ok);
    chk("R8 flag one cycle after accept", 32'(w), 32'd1);
    chk("R8 success", 32'(ok), 32'd1);
    chk("R8 memory written", mem[12], 32'h5C5C_5C5C);
  endtask

  task automatic t_snoop_fail_retry();
    int base, w; logic [31:0] d; logic ok;
    send(LRS, 13, 32'h0, 4'hF);
    wait_rsp(w, d, ok);
    @(negedge clk); snoop_valid = 1'b1; snoop_addr = wa(13) + 16'd2;
    @(negedge clk); snoop_valid = 1'b0;
    base = wr_count;
    send(SCD, 13, 32'h1313_1313, 4'hF);
    wait_rsp(w, d, ok);
    chk("R10 snoop disarms, sc fails", 32'(ok), 32'd0);
    chk("R9 fail response timing", 32'(w), 32'd1);
    chk("R9 no write on fail", 32'(wr_count - base), 32'd0);
    chk("R9 memory unchanged", mem[13], 32'hA000_000D);
    send(LRS, 13, 32'h0, 4'hF);
    wait_rsp(w, d, ok);
    send(SCD, 13, 32'h1313_1313, 4'hF);
    wait_rsp(w, d, ok);
    chk("R8 retry succeeds", 32'(ok), 32'd1);
    chk("R8 retry wrote", mem[13], 32'h1313_1313);
  endtask

  task automatic t_snoop_other();
    int w; logic [31:0] d; logic ok;
    send(LRS, 14, 32'h0, 4'hF);
    wait_rsp(w, d, ok);
    @(negedge clk); snoop_valid = 1'b1; snoop_addr = wa(15);
    @(negedge clk); snoop_valid = 1'b0;
    send(SCD, 14, 32'h1414_1414, 4'hF);
    wait_rsp(w, d, ok);
    chk("R10 other-word snoop keeps reservation", 32'(ok), 32'd1);
    send(SCD, 14, 32'hFFFF_FFFF, 4'hF);
    wait_rsp(w, d, ok);
    chk("R9 sc without reservation fails", 32'(ok), 32'd0);
    chk("R9 memory keeps first sc", mem[14], 32'h1414_1414);
  endtask

  task automatic t_coincident();
    int w; logic [31:0] d; logic ok;
    send(LRS, 2, 32'h0, 4'hF);
    wait_rsp(w, d, ok);
    send(SCD, 2, 32'hBAD0_BAD0, 4'hF);
    snoop_valid = 1'b1; snoop_addr = wa(2);
    @(negedge clk); snoop_valid = 1'b0;
    wait_rsp(w, d, ok);
    chk("R10 same-cycle snoop wins", 32'(ok), 32'd0);
    chk("R10 memory unchanged", mem[2], 32'h2222_2222);
  endtask

  task automatic t_reset_midflight();
    int base, w; logic [31:0] d; logic ok;
    send(LRS, 3, 32'h0, 4'hF);
    wait_rsp(w, d, ok);
    mem_stall = 1'b1;
    send(STR, 4, 32'h9999_9999, 4'hF);
    send(SYN, 0, 32'h0, 4'h0);
    base = wr_count;
    do_reset();
    mem_stall = 1'b0;
    quiet(6, "R11 pending sync dropped");
    chk("R11 queued store discarded", 32'(wr_count - base), 32'd0);
    chk("R11 memory untouched", mem[4], 32'hA000_0004);
    chk("R11 ready again", 32'(req_ready), 32'd1);
    send(SCD, 3, 32'h3333_3333, 4'hF);
    wait_rsp(w, d, ok);
    chk("R11 reservation cleared", 32'(ok), 32'd0);
  endtask

  initial begin
    t_reset_state();
    t_order_full();
    t_forward();
    t_partial();
    t_bypass();
    t_sync();
    t_lr_sc_ok();
    t_snoop_fail_retry();
    t_snoop_other();
    t_coincident();
    t_reset_midflight();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule